// File: doc/BRIEF.md
# Ping-Pong Converter Output Demultiplexer

This block is the digital back end of a pipelined 8-bit sampling converter. On every rising edge of the sample clock it takes one conversion code, already digital, and carries it through a fixed-latency delay line. A mode input then decides how results leave the block. In single-port mode every result goes to port A. In dual-port mode consecutive results alternate between port A and port B, so each port updates at half the sample rate.

The alternation is driven by an internal divide-by-two steering toggle. Its phase after reset comes from a seed input, so the pairing of even samples to a port is not known to the consumer. A falling edge on the sync input forces the toggle into a defined phase. The sync input is sampled on the falling edge of the sample clock.

If the forced phase differs from the running phase, one result on each port is flagged as corrupt while the block realigns. If the phases already agree, the sync has no effect. Because of this, a sync pulse train at half the sample rate can run continuously. Codes are straight binary: 0 is the most negative input and 255 the most positive.

Top module: `adc_pingpong_demux`

## Requirements
- R1: While reset is asserted, port_a and port_b read 0, and valid_a and valid_b read 0.
- R2: With mode_single high, the code taken at rising edge k appears on port_a after rising edge k+4. valid_a is high for every code taken after reset release.
- R3: With mode_single high, port_b does not change and valid_b is low.
- R4: With mode_single low, the code taken at edge k appears after edge k+5. It goes to port_a or port_b, and successive edges load the two ports alternately. A port that is not loaded holds its data and flag.
- R5: Edges are counted from 1, starting at the first rising edge after reset release. In dual-port mode, port_a is loaded on odd edges when phase_seed is 0 and on even edges when it is 1.
- R6: sync_in is sampled on each falling clock edge. A fall is taken at rising edge F when the falling-edge sample just before F is 0 and the one before edge F-1 was 1. The edge F+1 then loads port_a, and alternation continues from there.
- R7: Take a dual-mode fall whose forced phase differs from the running phase. The first load of each port after it carries its code with the valid flag low. Later loads are valid again.
- R8: A fall whose forced phase equals the running phase changes nothing at the ports. This includes a continuous sync train at half the sample rate.
- R9: Codes pass through unmodified in straight binary, including the end codes 0x00 and 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; a code is taken on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_single | input | 1 | 1: single-port output on port_a; 0: alternating dual-port output |
| phase_seed | input | 1 | Phase loaded into the steering toggle at reset |
| sync_in | input | 1 | Phase sync; a falling edge forces the steering phase |
| code_in | input | 8 | Conversion code, straight binary |
| port_a | output | 8 | Output port A |
| port_b | output | 8 | Output port B |
| valid_a | output | 1 | Port A holds a valid, uncorrupted result |
| valid_b | output | 1 | Port B holds a valid, uncorrupted result |

## Verification
A steering toggle in the wrong phase puts a result on the wrong port. That shows within two edges of the first valid result, or within two edges of any sync. A delay line of the wrong length shows as a mismatched code on the first valid result after reset, at edge 5 or 6. A resync that mishandles the corruption flags shows as a missing or extra low valid flag on the first load of each port after the sync. This appears within three edges. It is tested with both seeds, with single misaligned and aligned sync pulses, and with a continuous half-rate sync train.

// File: rtl/adc_demux_pkg.sv
package adc_demux_pkg;
  // Port that the steering toggle selects for the next dual-mode load
  typedef enum logic {
    PORT_A = 1'b0,
    PORT_B = 1'b1
  } port_sel_e;
endpackage

// File: rtl/adc_code_pipe.sv
module adc_code_pipe #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [W-1:0]              code_i,
  output logic [DEPTH-1:0][W-1:0]   data_o,
  output logic [DEPTH-1:0]          vld_o
);
  logic [DEPTH-1:0][W-1:0] data_d, data_q;
  logic [DEPTH-1:0]        vld_d, vld_q;

  // Stage 0 takes the new code; every later stage shifts from its neighbour
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign data_d[g] = code_i;
      assign vld_d[g]  = 1'b1;
    end else begin : g_body
      assign data_d[g] = data_q[g-1];
      assign vld_d[g]  = vld_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= '0;
    end else begin
      data_q <= data_d;
      vld_q  <= vld_d;
    end
  end

  assign data_o = data_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/adc_sync_detect.sv
module adc_sync_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic sync_fall
);
  logic smp_q;
  logic prev_q;

  // Sync is sampled against the falling clock edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= 1'b0;
    else        smp_q <= sync_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= smp_q;
  end

  assign sync_fall = prev_q & ~smp_q;

  // R6: a captured fall lasts one cycle; a second fall needs a new high sample
  a_r6_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fall |=> !sync_fall);
endmodule

// File: rtl/adc_phase_toggle.sv
module adc_phase_toggle
  import adc_demux_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      seed_i,
  input  logic      sync_fall,
  input  logic      dual_mode,
  input  logic      take_a,
  input  logic      take_b,
  output port_sel_e sel_o,
  output logic      bad_a_o,
  output logic      bad_b_o
);
  port_sel_e tog_d, tog_q;
  logic      bad_a_d, bad_a_q, bad_b_d, bad_b_q;
  logic      realign;

  // Forcing to PORT_A conflicts with the running phase when the natural
  // next value would have been PORT_B, i.e. when port A is selected now
  assign realign = sync_fall & dual_mode & (tog_q == PORT_A);

  always_comb begin
    if (sync_fall)             tog_d = PORT_A;
    else if (tog_q == PORT_A)  tog_d = PORT_B;
    else                       tog_d = PORT_A;

    bad_a_d = bad_a_q;
    bad_b_d = bad_b_q;
    if (take_a) bad_a_d = 1'b0;
    if (take_b) bad_b_d = 1'b0;
    if (realign) begin
      bad_a_d = 1'b1;
      bad_b_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q   <= port_sel_e'(seed_i);
      bad_a_q <= 1'b0;
      bad_b_q <= 1'b0;
    end else begin
      tog_q   <= tog_d;
      bad_a_q <= bad_a_d;
      bad_b_q <= bad_b_d;
    end
  end

  assign sel_o   = tog_q;
  assign bad_a_o = bad_a_q;
  assign bad_b_o = bad_b_q;

  // R4: without a sync the toggle alternates on every edge
  a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_fall |=> tog_q != $past(tog_q));
  // R6: a captured fall leaves port A selected for the next edge
  a_r6_forced_a: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fall |=> tog_q == PORT_A);
  // R8: an aligned fall raises no corruption flag
  a_r8_aligned_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_fall && tog_q == PORT_B && !bad_a_q && !bad_b_q) |=> (!bad_a_q && !bad_b_q));
endmodule

// File: rtl/adc_pingpong_demux.sv
module adc_pingpong_demux
  import adc_demux_pkg::*;
#(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned SINGLE_LAT = 4,
  parameter int unsigned DUAL_LAT   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_single,
  input  logic              phase_seed,
  input  logic              sync_in,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] port_a,
  output logic [CODE_W-1:0] port_b,
  output logic              valid_a,
  output logic              valid_b
);
  localparam int unsigned DEPTH = (DUAL_LAT > SINGLE_LAT) ? DUAL_LAT : SINGLE_LAT;
  localparam int unsigned TAP_S = SINGLE_LAT - 1;
  localparam int unsigned TAP_D = DUAL_LAT - 1;

  logic [DEPTH-1:0][CODE_W-1:0] pipe_data;
  logic [DEPTH-1:0]             pipe_vld;
  logic                         sync_fall;
  port_sel_e                    sel;
  logic                         bad_a, bad_b;
  logic                         take_a, take_b;

  logic [CODE_W-1:0] a_d, a_q, b_d, b_q;
  logic              va_d, va_q, vb_d, vb_q;

  adc_code_pipe #(.W(CODE_W), .DEPTH(DEPTH)) u_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .code_i (code_in),
    .data_o (pipe_data),
    .vld_o  (pipe_vld)
  );

  adc_sync_detect u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_in   (sync_in),
    .sync_fall (sync_fall)
  );

  adc_phase_toggle u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed_i    (phase_seed),
    .sync_fall (sync_fall),
    .dual_mode (~mode_single),
    .take_a    (take_a),
    .take_b    (take_b),
    .sel_o     (sel),
    .bad_a_o   (bad_a),
    .bad_b_o   (bad_b)
  );

  // Output steering: next-state logic
  always_comb begin
    a_d    = a_q;
    b_d    = b_q;
    va_d   = va_q;
    vb_d   = vb_q;
    take_a = 1'b0;
    take_b = 1'b0;
    if (mode_single) begin
      a_d  = pipe_data[TAP_S];
      va_d = pipe_vld[TAP_S];
      vb_d = 1'b0;
    end else if (sel == PORT_A) begin
      take_a = 1'b1;
      a_d    = pipe_data[TAP_D];
      va_d   = pipe_vld[TAP_D] & ~bad_a;
    end else begin
      take_b = 1'b1;
      b_d    = pipe_data[TAP_D];
      vb_d   = pipe_vld[TAP_D] & ~bad_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      va_q <= 1'b0;
      vb_q <= 1'b0;
    end else begin
      a_q  <= a_d;
      b_q  <= b_d;
      va_q <= va_d;
      vb_q <= vb_d;
    end
  end

  assign port_a  = a_q;
  assign port_b  = b_q;
  assign valid_a = va_q;
  assign valid_b = vb_q;

  // R3: single-port mode freezes port B and keeps its flag low
  a_r3_b_static: assert property (@(posedge clk) disable iff (!rst_n)
    mode_single |=> $stable(port_b));
  a_r3_b_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
    mode_single |=> !valid_b);
  // R4: in dual-port mode no edge updates both ports with new data
  a_r4_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_single |=> !((port_a != $past(port_a)) && (port_b != $past(port_b))));

  if (SINGLE_LAT == 4 && DUAL_LAT == 5) begin : g_lat_chk
    // R2: four-edge latency from the input port to port A
    a_r2_single_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_single && pipe_vld[TAP_S]) |=> port_a == $past(code_in, 5));
    // R4: five-edge latency into whichever port is selected
    a_r4_dual_latency_a: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_single && pipe_vld[TAP_D] && sel == PORT_A) |=> port_a == $past(code_in, 6));
    a_r4_dual_latency_b: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_single && pipe_vld[TAP_D] && sel == PORT_B) |=> port_b == $past(code_in, 6));
  end
endmodule

// File: tb/adc_pingpong_demux_bench.sv
module adc_pingpong_demux_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_single = 1'b1;
  logic       phase_seed = 1'b0;
  logic       sync_in = 1'b1;
  logic [7:0] code_in = '0;
  logic [7:0] port_a, port_b;
  logic       valid_a, valid_b;

  always #2 clk = ~clk;

  adc_pingpong_demux u_adc_pingpong_demux (
    .clk(clk), .rst_n(rst_n), .mode_single(mode_single), .phase_seed(phase_seed),
    .sync_in(sync_in), .code_in(code_in), .port_a(port_a), .port_b(port_b),
    .valid_a(valid_a), .valid_b(valid_b)
  );

  int checks = 0;
  int errors = 0;
  int n = 0;
  logic [7:0] hist [0:4095];
  logic       mode_h [0:4095];
  logic       drv_sync [0:4095];
  logic [7:0] exp_a, exp_b;
  logic       exp_va, exp_vb, bad_a, bad_b;
  int         a_par;
  string      cur_req = "R1";

  function automatic logic [7:0] h(input int k);
    return (k < 1) ? 8'h00 : hist[k];
  endfunction

  task automatic chk8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at edge %0d: actual %02h expected %02h", req, what, n, act, exp);
    end
  endtask

  // Reference model of the ports for rising edge n, written from the requirements
  task automatic model();
    logic m;
    logic fall;
    int   np;
    m = mode_h[n];
    if (m) begin
      exp_a  = h(n - 4);
      exp_va = (n - 4 >= 1);
      exp_vb = 1'b0;
    end else if ((n % 2) == a_par) begin
      exp_a  = h(n - 5);
      exp_va = (n - 5 >= 1) && !bad_a;
      bad_a  = 1'b0;
    end else begin
      exp_b  = h(n - 5);
      exp_vb = (n - 5 >= 1) && !bad_b;
      bad_b  = 1'b0;
    end
    fall = (drv_sync[n] == 1'b0) && (drv_sync[n-1] == 1'b1);
    if (fall) begin
      np = (n + 1) % 2;
      if (!m && np != a_par) begin
        bad_a = 1'b1;
        bad_b = 1'b1;
      end
      a_par = np;
    end
  endtask

  task automatic compare();
    string tb;
    tb = mode_h[n] ? "R3" : cur_req;
    chk8(cur_req, "port_a", port_a, exp_a);
    chk8(cur_req, "valid_a", {7'd0, valid_a}, {7'd0, exp_va});
    chk8(tb, "port_b", port_b, exp_b);
    chk8(tb, "valid_b", {7'd0, valid_b}, {7'd0, exp_vb});
  endtask

  // Called 1 ns after a rising edge; returns 1 ns after the next one
  task automatic step(input logic [7:0] c, input logic m, input logic s);
    code_in = c; mode_single = m; sync_in = s;
    hist[n+1] = c; mode_h[n+1] = m; drv_sync[n+1] = s;
    @(posedge clk);
    n++;
    model();
    #1;
    compare();
  endtask

  task automatic do_reset(input logic s, input logic m);
    @(posedge clk);
    #1;
    rst_n = 1'b0; phase_seed = s; mode_single = m; sync_in = 1'b1; code_in = '0;
    #1;
    // R1: reset state
    chk8("R1", "port_a", port_a, 8'h00);
    chk8("R1", "port_b", port_b, 8'h00);
    chk8("R1", "valid_a", {7'd0, valid_a}, 8'h00);
    chk8("R1", "valid_b", {7'd0, valid_b}, 8'h00);
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    n = 0; drv_sync[0] = 1'b0;
    exp_a = '0; exp_b = '0; exp_va = 1'b0; exp_vb = 1'b0;
    bad_a = 1'b0; bad_b = 1'b0;
    a_par = s ? 0 : 1;
  endtask

  // Drive one sync fall whose forced phase matches (aligned) or not
  task automatic sync_once(input logic aligned, input logic m);
    while (((n % 2) == a_par) != aligned) step(8'($urandom), m, 1'b1);
    step(8'($urandom), m, 1'b0);
    step(8'($urandom), m, 1'b1);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd7741);

    // Single-port pass-through, end codes, random codes
    do_reset(1'b0, 1'b1);
    cur_req = "R2";
    for (int i = 0; i < 30; i++) step(8'($urandom), 1'b1, 1'b1);
    cur_req = "R9";
    step(8'h00, 1'b1, 1'b1);
    step(8'hFF, 1'b1, 1'b1);
    step(8'h80, 1'b1, 1'b1);
    step(8'h7F, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) step(8'($urandom), 1'b1, 1'b1);
    // Switch to dual, then back to single: port B must freeze
    cur_req = "R4";
    for (int i = 0; i < 30; i++) step(8'($urandom), 1'b0, 1'b1);
    cur_req = "R2";
    for (int i = 0; i < 20; i++) step(8'($urandom), 1'b1, 1'b1);

    // Seed 0: first valid result goes to port B at edge 6
    do_reset(1'b0, 1'b0);
    cur_req = "R5";
    for (int i = 0; i < 6; i++) step(8'($urandom), 1'b0, 1'b1);
    chk8("R5", "seed0 valid_a", {7'd0, valid_a}, 8'h00);
    chk8("R5", "seed0 valid_b", {7'd0, valid_b}, 8'h01);
    chk8("R5", "seed0 port_b", port_b, hist[1]);
    for (int i = 0; i < 10; i++) step(8'($urandom), 1'b0, 1'b1);
    cur_req = "R6";
    sync_once(1'b0, 1'b0);
    for (int i = 0; i < 12; i++) step(8'($urandom), 1'b0, 1'b1);

    // Seed 1: first valid result goes to port A at edge 6
    do_reset(1'b1, 1'b0);
    cur_req = "R5";
    for (int i = 0; i < 6; i++) step(8'($urandom), 1'b0, 1'b1);
    chk8("R5", "seed1 valid_a", {7'd0, valid_a}, 8'h01);
    chk8("R5", "seed1 valid_b", {7'd0, valid_b}, 8'h00);
    chk8("R5", "seed1 port_a", port_a, hist[1]);
    for (int i = 0; i < 8; i++) step(8'($urandom), 1'b0, 1'b1);
    // Misaligned resync: one flagged result per port
    cur_req = "R7";
    sync_once(1'b0, 1'b0);
    for (int i = 0; i < 12; i++) step(8'($urandom), 1'b0, 1'b1);
    // Aligned single sync and continuous half-rate train
    cur_req = "R8";
    sync_once(1'b1, 1'b0);
    for (int i = 0; i < 6; i++) step(8'($urandom), 1'b0, 1'b1);
    for (int i = 0; i < 40; i++) step(8'($urandom), 1'b0, ((n % 2) == a_par) ? 1'b0 : 1'b1);
    step(8'($urandom), 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) step(8'($urandom), 1'b0, 1'b1);

    // Random mix of modes, codes and sync pulses
    cur_req = "R4";
    begin
      logic m;
      m = 1'b0;
      for (int i = 0; i < 400; i++) begin
        if (($urandom % 25) == 0) m = ~m;
        step(8'($urandom), m, (($urandom % 7) == 0) ? 1'b0 : 1'b1);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule